// File: doc/BRIEF.md
# DMA Channel Register File

This block is the register front end of a four-channel DMA engine. A host programs it over an 8-bit I/O bus with a 4-bit port offset. Each channel has a 16-bit address and a 16-bit transfer count. Both are reached through a single byte-wide port, and a shared byte-pointer bit decides whether an access hits the low byte or the high byte. Software clears that pointer first and then makes two accesses in a row, low byte first.

Control ports hold a command byte, per-channel request and mask bits, and a per-channel mode field. The status byte reports pending requests and terminal-count events. A master-clear port returns the control state to idle. The transfer engine, which is not part of this block, pulses a strobe with a channel number for each completed transfer. An unmasked channel then decrements its count. The count holds the transfer length minus one, so decrementing past zero wraps to 0xFFFF and flags terminal count.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every channel is masked (`ch_mask`=4'hF), the byte pointer selects the low byte, and all addresses, counts, modes, the command byte, request bits and terminal-count bits read as zero.
- R2: Offsets 2n and 2n+1 (n = 0..3) are the address and count ports of channel n. Each access to these ports (read or write) moves the byte pointer to the other byte. A write stores the selected byte and a read returns it on `io_rdata` in the same cycle, low byte first after a pointer clear.
- R3: Any write to offset 0xC returns the byte pointer to the low byte, whatever data is written.
- R4: A transfer strobe for an unmasked channel decrements that channel's count by one. A strobe for a masked channel leaves every count unchanged. A bus write to the same channel's count port in that cycle takes priority and drops the decrement.
- R5: A decrement from 0x0000 wraps the count to 0xFFFF and sets that channel's terminal-count bit.
- R6: Reading offset 0x8 returns {request[3:0], terminal_count[3:0]} and clears all terminal-count bits. A terminal count raised in the same cycle as the read survives.
- R7: A write to offset 0xA selects a channel with data[1:0]. It masks that channel when data[2]=1 and unmasks it when data[2]=0.
- R8: A write to offset 0xB stores data[7:2] as the 6-bit mode of the channel in data[1:0], shown on `ch_mode[6n+5:6n]`. For example, 0x45 gives channel 1 mode 0x11.
- R9: A write to offset 0xF loads the four mask bits from data[3:0]. A write to offset 0xE clears all four mask bits.
- R10: A write to offset 0xD sets all mask bits, returns the byte pointer to low, and clears the command byte, request bits and terminal-count bits. Addresses, counts and modes are kept.
- R11: A write to offset 0x9 sets (data[2]=1) or clears (data[2]=0) the request bit of channel data[1:0], shown on `req_pend`.
- R12: A write to offset 0x8 loads the command byte onto `cmd_reg`. Reads of offsets 0x9 to 0xF return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, valid in the cycle of `io_rd` |
| xfer_stb | input | 1 | One transfer completed |
| xfer_ch | input | 2 | Channel of the completed transfer |
| ch_mask | output | 4 | Per-channel mask bits |
| ch_mode | output | 24 | Per-channel 6-bit mode fields |
| cmd_reg | output | 8 | Command byte |
| req_pend | output | 4 | Software request bits |

## Verification
Four behaviours are checked by assertions on every cycle:
- a pointer-clear write always leaves the pointer on the low byte;
- a masked strobe never changes any count;
- a decrement from zero always raises a terminal-count bit;
- master clear always re-masks all channels, and a status read with no strobe leaves no terminal-count bit set.

Only the bench scenarios can show that bytes land in the right half of the right register, that readback matches earlier writes across long runs of random loads and strobes, and that the mode, request and command fields decode their bit positions correctly.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  parameter int MODE_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              io_addr,
  input  logic [7:0]              io_wdata,
  input  logic                    io_wr,
  input  logic                    io_rd,
  output logic [7:0]              io_rdata,
  input  logic                    xfer_stb,
  input  logic [1:0]              xfer_ch,
  output logic [NCH-1:0]          ch_mask,
  output logic [NCH*MODE_W-1:0]   ch_mode,
  output logic [7:0]              cmd_reg,
  output logic [NCH-1:0]          req_pend
);
  localparam logic [3:0] OFS_CMD = 4'h8, OFS_REQ = 4'h9, OFS_SMASK = 4'hA, OFS_MODE = 4'hB,
                         OFS_PTR = 4'hC, OFS_MCLR = 4'hD, OFS_UNMASK = 4'hE, OFS_AMASK = 4'hF;

  logic [NCH-1:0][CNT_W-1:0]  addr_q, cnt_q;
  logic [NCH-1:0][MODE_W-1:0] mode_q;
  logic [NCH-1:0] mask_q, tc_q, req_q;
  logic [7:0] cmd_q;
  logic ptr_q;

  wire       ch_port  = ~io_addr[3];
  wire [1:0] pch      = io_addr[2:1];
  wire       is_cnt   = io_addr[0];
  wire       acc      = ch_port & (io_wr | io_rd);
  wire       stat_rd  = io_rd & (io_addr == OFS_CMD);
  wire       mclr     = io_wr & (io_addr == OFS_MCLR);
  wire       dec      = xfer_stb & ~mask_q[xfer_ch];
  wire       bus_hit  = io_wr & ch_port & is_cnt & (pch == xfer_ch);
  wire [CNT_W-1:0] sel = is_cnt ? cnt_q[pch] : addr_q[pch];

  assign ch_mask  = mask_q;
  assign ch_mode  = mode_q;
  assign cmd_reg  = cmd_q;
  assign req_pend = req_q;

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (ch_port)                  io_rdata = ptr_q ? sel[15:8] : sel[7:0];
      else if (io_addr == OFS_CMD)  io_rdata = {req_q, tc_q};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; cnt_q <= '0; mode_q <= '0;
      mask_q <= '1; tc_q <= '0; req_q <= '0; cmd_q <= '0; ptr_q <= 1'b0;
    end else begin
      if (acc) ptr_q <= ~ptr_q;
      if (stat_rd) tc_q <= '0;
      if (dec && !bus_hit) begin
        cnt_q[xfer_ch] <= cnt_q[xfer_ch] - 1'b1;
        if (cnt_q[xfer_ch] == '0) tc_q[xfer_ch] <= 1'b1;
      end
      if (io_wr) begin
        if (ch_port) begin
          if (is_cnt) begin
            if (ptr_q) cnt_q[pch][15:8] <= io_wdata; else cnt_q[pch][7:0] <= io_wdata;
          end else begin
            if (ptr_q) addr_q[pch][15:8] <= io_wdata; else addr_q[pch][7:0] <= io_wdata;
          end
        end else begin
          case (io_addr)
            OFS_CMD:    cmd_q <= io_wdata;
            OFS_REQ:    req_q[io_wdata[1:0]] <= io_wdata[2];
            OFS_SMASK:  mask_q[io_wdata[1:0]] <= io_wdata[2];
            OFS_MODE:   mode_q[io_wdata[1:0]] <= io_wdata[7:2];
            OFS_PTR:    ptr_q <= 1'b0;
            OFS_MCLR: begin
              mask_q <= '1; ptr_q <= 1'b0; cmd_q <= '0; req_q <= '0; tc_q <= '0;
            end
            OFS_UNMASK: mask_q <= '0;
            OFS_AMASK:  mask_q <= io_wdata[3:0];
            default: ;
          endcase
        end
      end
    end
  end

  AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == OFS_PTR) |=> !ptr_q); // R3
  AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_stb && mask_q[xfer_ch] && !io_wr) |=> $stable(cnt_q)); // R4
  AST_TC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !bus_hit && !mclr && cnt_q[xfer_ch] == '0) |=> (tc_q != '0)); // R5
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !xfer_stb) |=> (tc_q == '0)); // R6
  AST_MCLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_q == '1 && req_q == '0 && cmd_q == 8'h00)); // R10
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic io_wr = 1'b0, io_rd = 1'b0, xfer_stb = 1'b0;
  logic [1:0] xfer_ch = '0;
  logic [3:0] ch_mask, req_pend;
  logic [23:0] ch_mode;
  logic [7:0] cmd_reg;
  int errors = 0, checks = 0;
  logic [15:0] m_cnt [4];
  logic [3:0]  m_mask, m_tc;

  always #10 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (.*);

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] a, input logic [7:0] d,
                     input logic s, input logic [1:0] c, output logic [7:0] q);
    @(negedge clk);
    io_wr = w; io_rd = ~w; io_addr = a; io_wdata = d; xfer_stb = s; xfer_ch = c;
    #2 q = io_rdata;
    @(posedge clk); #1;
    io_wr = 0; io_rd = 0; xfer_stb = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] q; bus(1'b1, a, d, 1'b0, 2'd0, q);
  endtask
  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    bus(1'b0, a, 8'h00, 1'b0, 2'd0, q);
  endtask
  task automatic xfer(input logic [1:0] c);
    @(negedge clk); xfer_stb = 1; xfer_ch = c;
    @(posedge clk); #1 xfer_stb = 0;
  endtask
  task automatic wr16(input logic [3:0] a, input logic [15:0] v);
    wr(4'hC, 8'h00); wr(a, v[7:0]); wr(a, v[15:8]);
  endtask
  task automatic rd16(input logic [3:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(4'hC, 8'h5A); rd(a, lo); rd(a, hi); v = {hi, lo};
  endtask

  function automatic logic [15:0] after_dec(input logic [15:0] c);
    return c - 16'd1;
  endfunction

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v; logic [7:0] q;
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    chk("R1 mask", ch_mask, 4'hF); chk("R1 cmd", cmd_reg, 0);
    chk("R1 mode", ch_mode, 0); chk("R1 req", req_pend, 0);
    rd(4'h8, q); chk("R1 status", q, 0);
    rd(4'h1, q); rd(4'h1, q); chk("R1 count hi", q, 0);
    // R2
    wr16(4'h2, 16'h1234); rd16(4'h2, v); chk("R2 addr ch1", v, 16'h1234);
    wr16(4'h5, 16'hBEEF); rd16(4'h5, v); chk("R2 count ch2", v, 16'hBEEF);
    // R3
    wr(4'hC, 8'h00); wr(4'h0, 8'h11); wr(4'hC, 8'hFF); wr(4'h0, 8'h22); wr(4'h0, 8'h33);
    rd16(4'h0, v); chk("R3 ptr clear", v, 16'h3322);
    // R7
    wr(4'hA, 8'h02); chk("R7 unmask ch2", ch_mask, 4'b1011);
    wr(4'hA, 8'h06); chk("R7 mask ch2", ch_mask, 4'b1111);
    wr(4'hA, 8'h02);
    // R4
    wr16(4'h5, 16'h0003); xfer(2'd2); xfer(2'd2); xfer(2'd3);
    rd16(4'h5, v); chk("R4 decrement", v, 16'h0001);
    rd16(4'h7, v); chk("R4 masked ignored", v, 16'h0000);
    wr(4'hC, 8'h00); bus(1'b1, 4'h5, 8'h40, 1'b1, 2'd2, q); wr(4'h5, 8'h00);
    rd16(4'h5, v); chk("R4 bus write wins", v, 16'h0040);
    // R5 / R6
    wr16(4'h5, 16'h0000); xfer(2'd2);
    rd16(4'h5, v); chk("R5 wrap", v, 16'hFFFF);
    rd(4'h8, q); chk("R5 tc set", q, 8'h04);
    rd(4'h8, q); chk("R6 tc cleared", q, 8'h00);
    wr16(4'h5, 16'h0000);
    bus(1'b0, 4'h8, 8'h00, 1'b1, 2'd2, q); chk("R6 status before", q, 8'h00);
    rd(4'h8, q); chk("R6 set wins", q, 8'h04);
    // R8
    wr(4'hB, 8'h45); chk("R8 mode ch1", ch_mode[11:6], 6'h11);
    wr(4'hB, 8'hC3); chk("R8 mode ch3", ch_mode[23:18], 6'h30);
    // R9
    wr(4'hF, 8'h05); chk("R9 all mask", ch_mask, 4'b0101);
    wr(4'hE, 8'h00); chk("R9 clear mask", ch_mask, 4'b0000);
    // R11 / R12
    wr(4'h9, 8'h06); chk("R11 req set", req_pend, 4'b0100);
    rd(4'h8, q); chk("R11 status req", q, 8'h40);
    wr(4'h9, 8'h02); chk("R11 req clr", req_pend, 4'b0000);
    wr(4'h8, 8'hA5); chk("R12 cmd", cmd_reg, 8'hA5);
    rd(4'hB, q); chk("R12 wo read", q, 8'h00);
    // R10
    wr16(4'h7, 16'h0000); xfer(2'd3); wr(4'h9, 8'h05);
    wr(4'hC, 8'h00); wr(4'h6, 8'h99);
    wr(4'hD, 8'h00);
    chk("R10 mask", ch_mask, 4'hF); chk("R10 cmd", cmd_reg, 0); chk("R10 req", req_pend, 0);
    rd(4'h8, q); chk("R10 status", q, 0);
    wr(4'h6, 8'h78); wr(4'h6, 8'h56); rd16(4'h6, v); chk("R10 ptr low", v, 16'h5678);
    chk("R10 mode kept", ch_mode[11:6], 6'h11);
    // random: R2 R4 R5 R6
    m_mask = 4'hF; m_tc = 0;
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 16'($urandom % 4); wr16(4'(2*i+1), m_cnt[i]); end
    for (int n = 0; n < 400; n++) begin
      int op = $urandom % 6;
      logic [1:0] c = 2'($urandom);
      if (op == 0) begin m_mask = 4'($urandom); wr(4'hF, {4'h0, m_mask}); end
      else if (op == 1) begin m_cnt[c] = 16'($urandom % 3); wr16(4'({c, 1'b1}), m_cnt[c]); end
      else if (op == 2) begin rd16(4'({c, 1'b1}), v); chk("R4 random count", v, m_cnt[c]); end
      else if (op == 3) begin rd(4'h8, q); chk("R6 random status", q, {4'h0, m_tc}); m_tc = 0; end
      else begin
        xfer(c);
        if (!m_mask[c]) begin
          if (m_cnt[c] == 0) m_tc[c] = 1'b1;
          m_cnt[c] = after_dec(m_cnt[c]);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule